// File: doc/BRIEF.md
# Load/Store Handshake Rule Monitor

This block watches one load/store handshake port between a requesting unit and a memory-side responder. It raises an error flag whenever either side breaks the port's timing rules. It sees every control wire of the port: the two operation selects, the busy indication, the address valid flag and value, the one-cycle address accept and address exception pulses, and the one-cycle load and store data strobes. It keeps only enough state to know three things: whether an operation is open, whether its address has been presented (and what that address was), and whether the address has been accepted. It never looks at data values or memory contents.

Each rule owns one bit of an error vector. A bit is set on the clock edge that follows the offending cycle and stays set until the clear input is pulsed. A summary flag is high whenever any bit is set. The rules are cycle-exact. Address accept, address exception and both data strobes must each last exactly one cycle. Busy must fall in the same cycle as an exception or a load strobe, but only in the cycle after a store strobe.

An operation opens on the rising edge of the combined select (load or store). It closes after the cycle in which busy is allowed to fall: an exception, a load strobe, or the cycle after a store strobe.

Top module: `lsport_rule_monitor`

## Requirements
- R1: Load select and store select both high in one cycle sets error bit 0.
- R2: A rising edge of (load select OR store select) in a cycle where busy is high sets error bit 1.
- R3: Once an operation is open (from the cycle after its select rises), busy low sets error bit 2. The exception: busy may be low in a cycle carrying an address exception or a load strobe, or in the cycle after a store strobe.
- R4: After the address valid flag has first been seen high in an operation, any cycle with busy high in which the flag is low, or the address differs from the first presented value, sets error bit 3.
- R5: Address accept high in two consecutive cycles sets error bit 4. Address exception high in two consecutive cycles sets error bit 5.
- R6: Address exception high while busy is high sets error bit 6.
- R7: Load strobe high in two consecutive cycles sets error bit 7. Load strobe high while busy is high sets error bit 8.
- R8: A store strobe with no address accept earlier in the same operation sets error bit 9. This includes an accept in the same cycle as the strobe. Store strobe high in two consecutive cycles sets error bit 10.
- R9: Busy high in the cycle after a store strobe sets error bit 11. Busy high in the strobe cycle itself is legal.
- R10: Address accept and address exception high in the same cycle sets error bit 12.
- R11: Error bits are sticky and visible one cycle after the offending cycle. The any-error output is high exactly when some bit is set.
- R12: A clear pulse zeroes every bit on the next edge. Any violation in the clear cycle itself is dropped.
- R13: After reset all error bits and the any-error output are zero.
- R14: A legal store, a legal load with a wait cycle, and a load ended by an exception set no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Clears all sticky error bits |
| ld_sel | input | 1 | Load operation select |
| st_sel | input | 1 | Store operation select |
| busy | input | 1 | Port busy indication from the responder |
| adr_vld | input | 1 | Address valid flag from the requester |
| adr_val | input | ADDR_W | Address value |
| adr_ack | input | 1 | Address accepted pulse |
| adr_exc | input | 1 | Address exception pulse |
| ld_vld | input | 1 | Load data valid pulse |
| st_vld | input | 1 | Store data valid pulse |
| err_code | output | 13 | Sticky per-rule error bits, indexed as in the requirements |
| err_any | output | 1 | High when any error bit is set |

## Verification
The bench aims at the off-by-one edges of the busy rules:
- A store whose busy falls in the strobe cycle, or one cycle late, must flag bit 11 only in the late case. A monitor shifted by one cycle would flag the legal store, or miss the late one.
- An accept arriving in the same cycle as the store strobe must still count as early.
- An address that changes only after it was first presented must be caught.
- A pulse lasting two cycles must be flagged. A monitor that only checked levels would stay silent.
- A violation coinciding with a clear must be discarded, so a clear with the wrong priority would leave a bit set.

// File: rtl/lsmon_pkg.sv
package lsmon_pkg;

   localparam int unsigned NRULE = 13;

   localparam int unsigned B_BOTH_SEL  = 0;
   localparam int unsigned B_REQ_BUSY  = 1;
   localparam int unsigned B_BUSY_LOST = 2;
   localparam int unsigned B_ADR_MOVED = 3;
   localparam int unsigned B_ACK_LONG  = 4;
   localparam int unsigned B_EXC_LONG  = 5;
   localparam int unsigned B_EXC_BUSY  = 6;
   localparam int unsigned B_LD_LONG   = 7;
   localparam int unsigned B_LD_BUSY   = 8;
   localparam int unsigned B_ST_EARLY  = 9;
   localparam int unsigned B_ST_LONG   = 10;
   localparam int unsigned B_ST_BUSY   = 11;
   localparam int unsigned B_ACK_EXC   = 12;

   typedef struct packed {
      logic rise;      // select edge this cycle
      logic drop_ok;   // busy may be low this cycle
      logic active;    // operation open
      logic adr_held;  // address captured for this operation
      logic acked;     // address accepted earlier in this operation
      logic ack_q;
      logic exc_q;
      logic ld_q;
      logic st_q;
   } trk_t;

endpackage

// File: rtl/lsmon_track.sv
module lsmon_track
   import lsmon_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_sel,
   input  logic              st_sel,
   input  logic              adr_vld,
   input  logic [ADDR_W-1:0] adr_val,
   input  logic              adr_ack,
   input  logic              adr_exc,
   input  logic              ld_vld,
   input  logic              st_vld,
   output trk_t              trk,
   output logic [ADDR_W-1:0] adr_ref
);

   logic req_q, active_q, held_q, acked_q;
   logic ack_q, exc_q, ld_q, st_q;
   logic req, rise, drop_ok, fin;

   always_comb begin
      req     = ld_sel | st_sel;
      rise    = req & ~req_q;
      drop_ok = adr_exc | ld_vld | st_q;
      fin     = active_q & drop_ok & ~rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q    <= 1'b0;
         active_q <= 1'b0;
         held_q   <= 1'b0;
         acked_q  <= 1'b0;
         ack_q    <= 1'b0;
         exc_q    <= 1'b0;
         ld_q     <= 1'b0;
         st_q     <= 1'b0;
         adr_ref  <= '0;
      end else begin
         req_q    <= req;
         ack_q    <= adr_ack;
         exc_q    <= adr_exc;
         ld_q     <= ld_vld;
         st_q     <= st_vld;
         active_q <= rise | (active_q & ~drop_ok);
         if (rise) begin
            held_q  <= adr_vld;
            adr_ref <= adr_val;
         end else if (fin) begin
            held_q  <= 1'b0;
         end else if (active_q & ~held_q & adr_vld) begin
            held_q  <= 1'b1;
            adr_ref <= adr_val;
         end
         if (rise)
            acked_q <= adr_ack;
         else if (fin)
            acked_q <= 1'b0;
         else if (adr_ack)
            acked_q <= 1'b1;
      end
   end

   always_comb begin
      trk.rise     = rise;
      trk.drop_ok  = drop_ok;
      trk.active   = active_q;
      trk.adr_held = held_q;
      trk.acked    = acked_q;
      trk.ack_q    = ack_q;
      trk.exc_q    = exc_q;
      trk.ld_q     = ld_q;
      trk.st_q     = st_q;
   end

endmodule

// File: rtl/lsmon_rules.sv
module lsmon_rules
   import lsmon_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              ld_sel,
   input  logic              st_sel,
   input  logic              busy,
   input  logic              adr_vld,
   input  logic [ADDR_W-1:0] adr_val,
   input  logic              adr_ack,
   input  logic              adr_exc,
   input  logic              ld_vld,
   input  logic              st_vld,
   input  trk_t              trk,
   input  logic [ADDR_W-1:0] adr_ref,
   output logic [NRULE-1:0]  hit
);

   always_comb begin
      hit = '0;
      hit[B_BOTH_SEL]  = ld_sel & st_sel;
      hit[B_REQ_BUSY]  = trk.rise & busy;
      hit[B_BUSY_LOST] = trk.active & ~busy & ~trk.drop_ok;
      hit[B_ADR_MOVED] = busy & trk.adr_held & (~adr_vld | (adr_val != adr_ref));
      hit[B_ACK_LONG]  = adr_ack & trk.ack_q;
      hit[B_EXC_LONG]  = adr_exc & trk.exc_q;
      hit[B_EXC_BUSY]  = adr_exc & busy;
      hit[B_LD_LONG]   = ld_vld & trk.ld_q;
      hit[B_LD_BUSY]   = ld_vld & busy;
      hit[B_ST_EARLY]  = st_vld & ~trk.acked;
      hit[B_ST_LONG]   = st_vld & trk.st_q;
      hit[B_ST_BUSY]   = trk.st_q & busy;
      hit[B_ACK_EXC]   = adr_ack & adr_exc;
   end

endmodule

// File: rtl/lsmon_sticky.sv
module lsmon_sticky #(
   parameter int unsigned N = 13
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic [N-1:0] hit,
   output logic [N-1:0] flags
);

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags[i] <= 1'b0;
         else if (clr)
            flags[i] <= 1'b0;
         else if (hit[i])
            flags[i] <= 1'b1;
      end
   end

endmodule

// File: rtl/lsport_rule_monitor.sv
module lsport_rule_monitor
   import lsmon_pkg::*;
#(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              ld_sel,
   input  logic              st_sel,
   input  logic              busy,
   input  logic              adr_vld,
   input  logic [ADDR_W-1:0] adr_val,
   input  logic              adr_ack,
   input  logic              adr_exc,
   input  logic              ld_vld,
   input  logic              st_vld,
   output logic [NRULE-1:0]  err_code,
   output logic              err_any
);

   if (ADDR_W < 1 || ADDR_W > 128) begin : g_bad_width
      $error("lsport_rule_monitor: ADDR_W out of range");
   end

   trk_t              trk;
   logic [ADDR_W-1:0] adr_ref;
   logic [NRULE-1:0]  hit;

   lsmon_track #(.ADDR_W(ADDR_W)) u_track (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_sel  (ld_sel),
      .st_sel  (st_sel),
      .adr_vld (adr_vld),
      .adr_val (adr_val),
      .adr_ack (adr_ack),
      .adr_exc (adr_exc),
      .ld_vld  (ld_vld),
      .st_vld  (st_vld),
      .trk     (trk),
      .adr_ref (adr_ref)
   );

   lsmon_rules #(.ADDR_W(ADDR_W)) u_rules (
      .ld_sel  (ld_sel),
      .st_sel  (st_sel),
      .busy    (busy),
      .adr_vld (adr_vld),
      .adr_val (adr_val),
      .adr_ack (adr_ack),
      .adr_exc (adr_exc),
      .ld_vld  (ld_vld),
      .st_vld  (st_vld),
      .trk     (trk),
      .adr_ref (adr_ref),
      .hit     (hit)
   );

   lsmon_sticky #(.N(NRULE)) u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .hit   (hit),
      .flags (err_code)
   );

   assign err_any = |err_code;

endmodule

// File: rtl/lsmon_props.sv
module lsmon_props
   import lsmon_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             ld_sel,
   input logic             st_sel,
   input logic             busy,
   input logic             adr_ack,
   input logic             adr_exc,
   input logic             ld_vld,
   input logic [NRULE-1:0] err_code,
   input logic             err_any
);

   assert_both_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_sel && st_sel && !clr) |=> err_code[B_BOTH_SEL]);

   assert_exc_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (adr_exc && busy && !clr) |=> err_code[B_EXC_BUSY]);

   assert_ld_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_vld && busy && !clr) |=> err_code[B_LD_BUSY]);

   assert_ack_exc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (adr_ack && adr_exc && !clr) |=> err_code[B_ACK_EXC]);

   assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (err_code == '0));

   assert_any_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_any) |-> $past(clr));

   for (genvar i = 0; i < NRULE; i++) begin : g_hold
      assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (err_code[i] && !clr) |=> err_code[i]);
   end

endmodule

bind lsport_rule_monitor lsmon_props u_props (
   .clk      (clk),
   .rst_n    (rst_n),
   .clr      (clr),
   .ld_sel   (ld_sel),
   .st_sel   (st_sel),
   .busy     (busy),
   .adr_ack  (adr_ack),
   .adr_exc  (adr_exc),
   .ld_vld   (ld_vld),
   .err_code (err_code),
   .err_any  (err_any)
);

// File: tb/tb_lsport_rule_monitor.sv
`timescale 1ns/1ps
module tb_lsport_rule_monitor;

   localparam int AW = 16;
   localparam int NB = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clr = 1'b0;
   logic ld_sel = 1'b0, st_sel = 1'b0, busy = 1'b0, adr_vld = 1'b0;
   logic [AW-1:0] adr_val = '0;
   logic adr_ack = 1'b0, adr_exc = 1'b0, ld_vld = 1'b0, st_vld = 1'b0;
   logic [NB-1:0] err_code;
   logic err_any;

   int n_chk = 0;
   int n_bad = 0;
   bit running = 1'b0;

   always #2.5 clk = ~clk;

   lsport_rule_monitor #(.ADDR_W(AW)) dut (
      .clk(clk), .rst_n(rst_n), .clr(clr),
      .ld_sel(ld_sel), .st_sel(st_sel), .busy(busy),
      .adr_vld(adr_vld), .adr_val(adr_val),
      .adr_ack(adr_ack), .adr_exc(adr_exc),
      .ld_vld(ld_vld), .st_vld(st_vld),
      .err_code(err_code), .err_any(err_any)
   );

   // behavioural reference model
   bit [NB-1:0] m_err = '0;
   bit m_open = 0, m_seen = 0, m_acc = 0;
   int m_adr = 0;
   bit p_req = 0, p_ack = 0, p_exc = 0, p_ld = 0, p_st = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_err = '0; m_open = 0; m_seen = 0; m_acc = 0; m_adr = 0;
         p_req = 0; p_ack = 0; p_exc = 0; p_ld = 0; p_st = 0;
      end else begin
         automatic bit [NB-1:0] h = '0;
         automatic bit req = ld_sel || st_sel;
         automatic bit edge_up = req && !p_req;
         automatic bit may_drop = adr_exc || ld_vld || p_st;
         automatic bit ending = m_open && may_drop && !edge_up;
         if (ld_sel && st_sel) h[0] = 1;
         if (edge_up && busy) h[1] = 1;
         if (m_open && !busy && !may_drop) h[2] = 1;
         if (busy && m_seen && (!adr_vld || int'(adr_val) != m_adr)) h[3] = 1;
         if (adr_ack && p_ack) h[4] = 1;
         if (adr_exc && p_exc) h[5] = 1;
         if (adr_exc && busy) h[6] = 1;
         if (ld_vld && p_ld) h[7] = 1;
         if (ld_vld && busy) h[8] = 1;
         if (st_vld && !m_acc) h[9] = 1;
         if (st_vld && p_st) h[10] = 1;
         if (p_st && busy) h[11] = 1;
         if (adr_ack && adr_exc) h[12] = 1;
         if (clr) m_err = '0; else m_err = m_err | h;
         if (edge_up) begin
            m_seen = adr_vld; m_adr = int'(adr_val); m_acc = adr_ack;
         end else begin
            if (ending) begin m_seen = 0; m_acc = 0; end
            else begin
               if (m_open && !m_seen && adr_vld) begin m_seen = 1; m_adr = int'(adr_val); end
               if (adr_ack) m_acc = 1;
            end
         end
         m_open = edge_up || (m_open && !may_drop);
         p_req = req; p_ack = adr_ack; p_exc = adr_exc; p_ld = ld_vld; p_st = st_vld;
      end
   end

   // per-cycle comparison against the model (R11)
   always @(negedge clk) begin
      if (running && rst_n) begin
         n_chk++;
         if (err_code !== m_err || err_any !== (m_err != '0)) begin
            n_bad++;
            $display("FAIL R11 cycle compare: err_code=%b any=%b expected %b any=%b",
                     err_code, err_any, m_err, (m_err != '0));
         end
      end
   end

   task automatic chk(input string req, input logic [NB-1:0] act, input logic [NB-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic chk_bit(input string req, input int b, input bit exp);
      n_chk++;
      if (err_code[b] !== exp) begin
         n_bad++;
         $display("FAIL %s: bit %0d got %b expected %b", req, b, err_code[b], exp);
      end
   endtask

   task automatic step(input logic l, s, b, v, input logic [AW-1:0] a,
                       input logic k, e, dl, ds);
      ld_sel = l; st_sel = s; busy = b; adr_vld = v; adr_val = a;
      adr_ack = k; adr_exc = e; ld_vld = dl; st_vld = ds;
      @(negedge clk);
   endtask

   task automatic idle();
      step(0,0,0,0,'0,0,0,0,0);
   endtask

   task automatic restart();
      clr = 0;
      ld_sel = 0; st_sel = 0; busy = 0; adr_vld = 0; adr_val = '0;
      adr_ack = 0; adr_exc = 0; ld_vld = 0; st_vld = 0;
      rst_n = 0;
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      @(negedge clk);
   endtask

   initial begin
      #(5.0 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      @(negedge clk);
      restart();
      running = 1;
      chk("R13 reset state", err_code, '0);
      chk("R13 reset any", {12'b0, err_any}, '0);

      // R14 legal store, load with wait cycle, exception-ended load
      step(0,1,0,1,16'h0040,0,0,0,0);
      step(0,1,1,1,16'h0040,1,0,0,0);
      step(0,1,1,1,16'h0040,0,0,0,1);
      step(0,1,0,1,16'h0040,0,0,0,0);
      idle();
      step(1,0,0,1,16'h0040,0,0,0,0);
      step(1,0,1,1,16'h0040,1,0,0,0);
      step(1,0,1,1,16'h0040,0,0,0,0);
      step(1,0,0,1,16'h0040,0,0,1,0);
      idle();
      step(1,0,0,1,16'h0BAD,0,0,0,0);
      step(1,0,1,1,16'h0BAD,0,0,0,0);
      step(1,0,0,1,16'h0BAD,0,1,0,0);
      idle();
      chk("R14 legal sequences", err_code, '0);

      // R1
      restart();
      step(1,1,0,0,'0,0,0,0,0);
      chk_bit("R1 both selects", 0, 1);
      chk("R11 any set", {12'b0, err_any}, 13'd1);
      idle();
      chk_bit("R11 bit 0 sticky", 0, 1);

      // R2
      restart();
      step(1,0,0,1,16'h0010,0,0,0,0);
      step(1,0,1,1,16'h0010,0,0,0,0);
      step(0,0,1,1,16'h0010,0,0,0,0);
      step(0,1,1,1,16'h0010,0,0,0,0);
      chk_bit("R2 select rise while busy", 1, 1);

      // R3
      restart();
      step(0,1,0,1,16'h0020,0,0,0,0);
      step(0,1,0,1,16'h0020,0,0,0,0);
      chk_bit("R3 busy missing after request", 2, 1);

      // R4 address change, then valid drop
      restart();
      step(1,0,0,1,16'h0005,0,0,0,0);
      step(1,0,1,1,16'h0006,0,0,0,0);
      chk_bit("R4 address changed", 3, 1);
      restart();
      step(1,0,0,1,16'h0005,0,0,0,0);
      step(1,0,1,0,16'h0005,0,0,0,0);
      chk_bit("R4 valid dropped", 3, 1);

      // R5 long accept, then long exception
      restart();
      step(1,0,0,1,16'h0007,0,0,0,0);
      step(1,0,1,1,16'h0007,1,0,0,0);
      chk_bit("R5 single accept ok", 4, 0);
      step(1,0,1,1,16'h0007,1,0,0,0);
      chk_bit("R5 accept held", 4, 1);
      // R12 complete legally, then clear
      step(1,0,0,1,16'h0007,0,0,1,0);
      idle();
      clr = 1; idle(); clr = 0;
      chk("R12 clear zeroes", err_code, '0);
      idle();
      chk("R12 stays clear", err_code, '0);
      clr = 1; step(1,1,0,0,'0,0,0,0,0); clr = 0;
      chk("R12 clear wins over hit", err_code, '0);
      restart();
      step(1,0,0,1,16'h0008,0,0,0,0);
      step(1,0,0,1,16'h0008,0,1,0,0);
      step(1,0,0,1,16'h0008,0,1,0,0);
      chk_bit("R5 exception held", 5, 1);

      // R6
      restart();
      step(1,0,0,1,16'h0009,0,0,0,0);
      step(1,0,1,1,16'h0009,0,0,0,0);
      step(1,0,1,1,16'h0009,0,1,0,0);
      chk_bit("R6 exception with busy", 6, 1);

      // R7 long load strobe, then load strobe with busy
      restart();
      step(1,0,0,1,16'h000A,0,0,0,0);
      step(1,0,1,1,16'h000A,1,0,0,0);
      step(1,0,0,1,16'h000A,0,0,1,0);
      step(1,0,0,1,16'h000A,0,0,1,0);
      chk_bit("R7 load strobe held", 7, 1);
      restart();
      step(1,0,0,1,16'h000A,0,0,0,0);
      step(1,0,1,1,16'h000A,1,0,0,0);
      step(1,0,1,1,16'h000A,0,0,1,0);
      chk_bit("R7 load strobe with busy", 8, 1);

      // R8 early store (no accept, then same-cycle accept), long store
      restart();
      step(0,1,0,1,16'h000B,0,0,0,0);
      step(0,1,1,1,16'h000B,0,0,0,0);
      step(0,1,1,1,16'h000B,0,0,0,1);
      chk_bit("R8 store before accept", 9, 1);
      restart();
      step(0,1,0,1,16'h000B,0,0,0,0);
      step(0,1,1,1,16'h000B,0,0,0,0);
      step(0,1,1,1,16'h000B,1,0,0,1);
      chk_bit("R8 store with same-cycle accept", 9, 1);
      restart();
      step(0,1,0,1,16'h000C,0,0,0,0);
      step(0,1,1,1,16'h000C,1,0,0,0);
      step(0,1,1,1,16'h000C,0,0,0,1);
      step(0,1,0,1,16'h000C,0,0,0,1);
      chk_bit("R8 store strobe held", 10, 1);

      // R9
      restart();
      step(0,1,0,1,16'h000D,0,0,0,0);
      step(0,1,1,1,16'h000D,1,0,0,0);
      step(0,1,1,1,16'h000D,0,0,0,1);
      chk_bit("R9 busy in strobe cycle legal", 11, 0);
      step(0,1,1,1,16'h000D,0,0,0,0);
      chk_bit("R9 busy after store strobe", 11, 1);

      // R10
      restart();
      step(1,0,0,1,16'h000E,0,0,0,0);
      step(1,0,1,1,16'h000E,1,1,0,0);
      chk_bit("R10 accept and exception together", 12, 1);

      idle();
      running = 0;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule